// File: doc/BRIEF.md
# Subroutine Return Address Stack

This block keeps the return addresses of nested subroutine calls for a small processor with a 15-bit program counter. The pointer into the stack is not hidden state. It is the low three bits of the processor's upper status byte, and that byte lives inside this block. Software can read the pointer there and can overwrite it. The top entry is always visible, so the fetch logic can take its next address from it.

A call request carries the address of the calling instruction and a flag that gives the instruction's form. The block adds the instruction length and pushes the result: 3 bytes for a call with an absolute target and 2 bytes for one with a relative target. A return request carries a single condition-met bit, because the condition itself is evaluated outside the block. When that bit is set, the return takes the top entry and pops it. A variant of the return also re-enables interrupts by clearing the inhibit bit of the status byte.

Top module: `ras_unit`

## Requirements
- R1: After reset the pointer is 0, the status byte reads 0x00, the top entry reads 0 and `ret_taken` is low.
- R2: A call with `call_abs`=1 advances the pointer by one on the next clock and stores `call_pc`+3 (modulo 2^15) at the new pointer. `tos` then shows that value.
- R3: A call with `call_abs`=0 stores `call_pc`+2 (modulo 2^15) in the same way, so 0x7FFF yields 0x0001.
- R4: In a cycle with `ret_req` and `ret_cond_met` both high, `ret_taken` is high and `tos` already holds the return target. The pointer steps back by one on the next clock.
- R5: A return whose condition bit is low gives `ret_taken` low and leaves the pointer, the entries and the status byte unchanged.
- R6: A taken return with `ret_ei`=1 clears status bit 5 (the interrupt inhibit) on the next clock. With `ret_ei`=1 and the condition not met, bit 5 keeps its value.
- R7: The pointer wraps modulo 8. A ninth call overwrites the oldest entry, and a return taken at pointer 0 leaves the pointer at 7.
- R8: A status write (`psu_wr`) loads all 8 bits on the next clock, with bits 2..0 becoming the pointer. The following call stores its entry at that new pointer plus one.
- R9: A status write in the same cycle as a call or a return wins. That stack operation is dropped: no entry is written, `ret_taken` stays low, and the write alone decides the byte.
- R10: A call and a return requested in the same cycle are illegal. The block raises an internal clash flag that only its assertions observe.
- R11: A taken return with `ret_ei`=0 leaves status bits 7..3 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| call_req | input | 1 | Push request for a subroutine call |
| call_abs | input | 1 | 1: absolute-target call (3 bytes), 0: relative-target call (2 bytes) |
| call_pc | input | 15 | Address of the calling instruction |
| ret_req | input | 1 | Return request |
| ret_cond_met | input | 1 | Condition of the return is satisfied |
| ret_ei | input | 1 | Return also clears the interrupt inhibit bit |
| psu_wr | input | 1 | Write strobe for the upper status byte |
| psu_wdata | input | 8 | Data for the upper status byte |
| psu_q | output | 8 | Upper status byte; bits 2..0 are the pointer, bit 5 the inhibit |
| sp | output | 3 | Current stack pointer |
| tos | output | 15 | Entry at the current pointer (return target) |
| ret_taken | output | 1 | The return in this cycle pops the stack |

## Verification
The bench builds the block with its default parameters: a 15-bit address and a 3-bit pointer, which gives 8 entries. With these values, nine calls in a row are enough to show the oldest entry being overwritten. A call from 0x7FFF shows the address arithmetic wrapping. A pop from pointer 0 lands on 7 within a handful of cycles. A status write that moves the pointer to an arbitrary slot, followed by a call, shows that the new pointer is used at once.

// File: rtl/ras_pkg.sv
package ras_pkg;

  // Length in bytes of the calling instruction, by form.
  function automatic int unsigned call_len(input logic is_abs);
    return is_abs ? 3 : 2;
  endfunction

  // Return link = caller address + instruction length, wrapped to ADDR_W bits.
  function automatic logic [31:0] link_addr(input logic [31:0] pc,
                                            input logic is_abs,
                                            input int unsigned addr_w);
    logic [31:0] sum;
    logic [31:0] mask;
    sum  = pc + 32'(call_len(is_abs));
    mask = (32'd1 << addr_w) - 32'd1;
    return sum & mask;
  endfunction

endpackage

// File: rtl/ras_store.sv
module ras_store #(
  parameter int ADDR_W = 15,
  parameter int PTR_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic [PTR_W-1:0]  rd_idx,
  output logic [ADDR_W-1:0] rd_data
);
  localparam int DEPTH = 1 << PTR_W;

  logic [ADDR_W-1:0] slot [DEPTH];
  logic [DEPTH-1:0]  hit;

  for (genvar g = 0; g < DEPTH; g++) begin : g_hit
    assign hit[g] = wr_en && (wr_idx == PTR_W'(g));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (!rst_n)      slot[i] <= '0;
      else if (hit[i]) slot[i] <= wr_data;
    end
  end

  assign rd_data = slot[rd_idx];
endmodule

// File: rtl/ras_stat.sv
module ras_stat #(
  parameter int PTR_W   = 3,
  parameter int PSU_W   = 8,
  parameter int INH_BIT = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [PSU_W-1:0] wdata,
  input  logic             push,
  input  logic             pop,
  input  logic             clr_inh,
  output logic [PSU_W-1:0] psu
);
  logic [PSU_W-1:0] nxt;
  logic [PTR_W-1:0] ptr;

  assign ptr = psu[PTR_W-1:0];

  always_comb begin
    nxt = psu;
    if (wr) begin
      nxt = wdata;
    end else begin
      if (push)     nxt[PTR_W-1:0] = ptr + PTR_W'(1);
      else if (pop) nxt[PTR_W-1:0] = ptr - PTR_W'(1);
      if (clr_inh)  nxt[INH_BIT] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) psu <= '0;
    else        psu <= nxt;
  end
endmodule

// File: rtl/ras_unit.sv
module ras_unit #(
  parameter int ADDR_W  = 15,
  parameter int PTR_W   = 3,
  parameter int PSU_W   = 8,
  parameter int INH_BIT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              call_req,
  input  logic              call_abs,
  input  logic [ADDR_W-1:0] call_pc,
  input  logic              ret_req,
  input  logic              ret_cond_met,
  input  logic              ret_ei,
  input  logic              psu_wr,
  input  logic [PSU_W-1:0]  psu_wdata,
  output logic [PSU_W-1:0]  psu_q,
  output logic [PTR_W-1:0]  sp,
  output logic [ADDR_W-1:0] tos,
  output logic              ret_taken
);
  // Named internal events, visible to the bound checker.
  logic              push_fire;
  logic              pop_fire;
  logic              clash;
  logic [ADDR_W-1:0] link;
  logic [PTR_W-1:0]  push_idx;
  logic [31:0]       link_w;

  assign clash     = call_req && ret_req;
  assign push_fire = call_req && !psu_wr;
  assign pop_fire  = ret_req && ret_cond_met && !psu_wr && !call_req;
  assign link_w    = ras_pkg::link_addr(32'(call_pc), call_abs, ADDR_W);
  assign link      = link_w[ADDR_W-1:0];
  assign sp        = psu_q[PTR_W-1:0];
  assign push_idx  = sp + PTR_W'(1);
  assign ret_taken = pop_fire;

  ras_stat #(.PTR_W(PTR_W), .PSU_W(PSU_W), .INH_BIT(INH_BIT)) u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (psu_wr),
    .wdata   (psu_wdata),
    .push    (push_fire),
    .pop     (pop_fire),
    .clr_inh (pop_fire && ret_ei),
    .psu     (psu_q)
  );

  ras_store #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (push_fire),
    .wr_idx  (push_idx),
    .wr_data (link),
    .rd_idx  (sp),
    .rd_data (tos)
  );
endmodule

// File: rtl/ras_chk.sv
module ras_chk #(
  parameter int ADDR_W  = 15,
  parameter int PTR_W   = 3,
  parameter int PSU_W   = 8,
  parameter int INH_BIT = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              call_req,
  input logic              ret_req,
  input logic              ret_cond_met,
  input logic              ret_ei,
  input logic              psu_wr,
  input logic [PSU_W-1:0]  psu_wdata,
  input logic [PSU_W-1:0]  psu_q,
  input logic [PTR_W-1:0]  sp,
  input logic [ADDR_W-1:0] tos,
  input logic              ret_taken,
  input logic              push_fire,
  input logic              pop_fire,
  input logic              clash
);
  assert_reset_R1: assert property (@(posedge clk)
    !rst_n |=> (psu_q == '0 && tos == '0));

  assert_push_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    push_fire |=> sp == PTR_W'($past(sp) + PTR_W'(1)));

  assert_pop_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pop_fire |=> sp == PTR_W'($past(sp) - PTR_W'(1)));

  assert_untaken_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && !ret_cond_met && !call_req && !psu_wr) |=> psu_q == $past(psu_q));

  assert_inhibit_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_taken && ret_ei) |=> !psu_q[INH_BIT]);

  assert_status_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    psu_wr |=> psu_q == $past(psu_wdata));

  assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    psu_wr |-> !ret_taken);

  assert_no_clash_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !clash);

  assert_upper_keep_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_taken && !ret_ei) |=> psu_q[PSU_W-1:PTR_W] == $past(psu_q[PSU_W-1:PTR_W]));
endmodule

bind ras_unit ras_chk #(.ADDR_W(ADDR_W), .PTR_W(PTR_W), .PSU_W(PSU_W), .INH_BIT(INH_BIT)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .call_req     (call_req),
  .ret_req      (ret_req),
  .ret_cond_met (ret_cond_met),
  .ret_ei       (ret_ei),
  .psu_wr       (psu_wr),
  .psu_wdata    (psu_wdata),
  .psu_q        (psu_q),
  .sp           (sp),
  .tos          (tos),
  .ret_taken    (ret_taken),
  .push_fire    (push_fire),
  .pop_fire     (pop_fire),
  .clash        (clash)
);

// File: tb/sim_ras_unit.sv
`timescale 1ns/100ps
module sim_ras_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        call_req = 1'b0, call_abs = 1'b0;
  logic [14:0] call_pc = '0;
  logic        ret_req = 1'b0, ret_cond_met = 1'b0, ret_ei = 1'b0;
  logic        psu_wr = 1'b0;
  logic [7:0]  psu_wdata = '0;
  logic [7:0]  psu_q;
  logic [2:0]  sp;
  logic [14:0] tos;
  logic        ret_taken;

  int vectors = 0;
  int misses  = 0;
  bit done    = 0;

  // Reference model: behavioural stack of 8 ints and a status int.
  int m_mem [8];
  int m_sp  = 0;
  int m_hi  = 0;  // status bits 7..3, stored in place (low bits zero)

  always #2 clk = ~clk;  // 250 MHz

  ras_unit u0 (
    .clk(clk), .rst_n(rst_n), .call_req(call_req), .call_abs(call_abs),
    .call_pc(call_pc), .ret_req(ret_req), .ret_cond_met(ret_cond_met),
    .ret_ei(ret_ei), .psu_wr(psu_wr), .psu_wdata(psu_wdata),
    .psu_q(psu_q), .sp(sp), .tos(tos), .ret_taken(ret_taken)
  );

  task automatic check(input string tag, input string what, input int got, input int exp);
    vectors++;
    if (got != exp) begin
      misses++;
      $display("FAIL %s %s got 0x%0h expected 0x%0h", tag, what, got, exp);
    end
  endtask

  task automatic check_state(input string tag);
    check(tag, "sp", int'(sp), m_sp);
    check(tag, "psu", int'(psu_q), m_hi | m_sp);
    check(tag, "tos", int'(tos), m_mem[m_sp]);
  endtask

  // One clock: drive after the falling edge, check combinational outputs,
  // advance the model at the rising edge, then check registered state.
  task automatic step(input bit c, input bit ab, input int pc, input bit r,
                      input bit cm, input bit ei, input bit w, input int wd,
                      input string tag);
    bit exp_taken;
    @(negedge clk);
    call_req = c; call_abs = ab; call_pc = 15'(pc);
    ret_req = r; ret_cond_met = cm; ret_ei = ei;
    psu_wr = w; psu_wdata = 8'(wd);
    #0.5;
    exp_taken = r && cm && !w && !c;
    check(tag, "ret_taken", int'(ret_taken), int'(exp_taken));
    if (exp_taken) check(tag, "return target", int'(tos), m_mem[m_sp]);
    if (w) begin
      m_sp = wd % 8;
      m_hi = wd - m_sp;
    end else if (c) begin
      m_sp = (m_sp + 1) % 8;
      m_mem[m_sp] = (pc + (ab ? 3 : 2)) % 32768;
    end else if (exp_taken) begin
      m_sp = (m_sp + 7) % 8;
      if (ei && (m_hi / 32) % 2 == 1) m_hi = m_hi - 32;
    end
    @(posedge clk);
    #0.5;
    check_state(tag);
    call_req = 0; ret_req = 0; ret_cond_met = 0; ret_ei = 0; psu_wr = 0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      misses++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) m_mem[i] = 0;
    repeat (3) @(posedge clk);
    #0.5;
    check_state("R1");
    check("R1", "ret_taken", int'(ret_taken), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2 / R3: link arithmetic for both call forms.
    step(1, 1, 'h0100, 0, 0, 0, 0, 0, "R2");
    step(1, 0, 'h0200, 0, 0, 0, 0, 0, "R3");
    step(1, 0, 'h7FFF, 0, 0, 0, 0, 0, "R3");
    step(1, 1, 'h7FFE, 0, 0, 0, 0, 0, "R2");
    // R5: condition not met, including with the interrupt variant.
    step(0, 0, 0, 1, 0, 0, 0, 0, "R5");
    step(0, 0, 0, 1, 0, 1, 0, 0, "R5");
    // R4: taken returns.
    step(0, 0, 0, 1, 1, 0, 0, 0, "R4");
    step(0, 0, 0, 1, 1, 0, 0, 0, "R4");
    // R8: status write relocates the pointer, next call uses it.
    step(0, 0, 0, 0, 0, 0, 1, 'hE5, "R8");
    step(1, 1, 'h1234, 0, 0, 0, 0, 0, "R8");
    // R11: plain return keeps the upper bits, inhibit included.
    step(0, 0, 0, 1, 1, 0, 0, 0, "R11");
    // R6: untaken interrupt return keeps the inhibit, taken one clears it.
    step(0, 0, 0, 1, 0, 1, 0, 0, "R6");
    step(0, 0, 0, 1, 1, 1, 0, 0, "R6");
    check("R6", "inhibit bit", int'(psu_q[5]), 0);
    // R9: status write beats a call and a return in the same cycle.
    step(0, 0, 0, 0, 0, 0, 1, 'h22, "R9");
    step(1, 1, 'h0500, 0, 0, 0, 1, 'h33, "R9");
    step(0, 0, 0, 1, 1, 1, 1, 'h21, "R9");
    check("R9", "inhibit bit", int'(psu_q[5]), 1);
    // R7: wrap from pointer 0 to 7, then nine calls overwrite the oldest.
    step(0, 0, 0, 0, 0, 0, 1, 'h00, "R7");
    step(0, 0, 0, 1, 1, 0, 0, 0, "R7");
    for (int k = 0; k < 9; k++) step(1, k % 2, 'h0010 * (k + 1), 0, 0, 0, 0, 0, "R7");
    for (int k = 0; k < 9; k++) step(0, 0, 0, 1, 1, 0, 0, 0, "R7");
    // R10 is illegal stimulus; it is covered by the bound assertion only.
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule